// File: doc/BRIEF.md
# Burst-Aligned Memory Read Master

This block moves a contiguous region of memory onto a streaming output. A command gives a start address and a length in bytes. The block cuts the region into read bursts on a memory-mapped bus that uses `burstcount` and `waitrequest`. The returned words pass through an internal FIFO and leave on a valid/ready stream in address order. A one-cycle `done` pulse marks the delivery of the last word.

A build-time option, `ALIGN_EN`, keeps every burst inside one window of `DATA_W/8 * MAX_BURST` bytes. With the option on, a region that starts part-way into a window first gets a short burst that ends exactly on the next window edge. Full-length bursts follow from there. This suits memories whose efficiency depends on bursts that do not straddle such edges. With the option off, the block issues full-length bursts from any start address.

Read issue is paced by credit. A burst goes out only when the FIFO has room for that burst plus every word already requested and not yet returned. Backpressure on the stream therefore never loses data.

Top module: `burst_rd_master`

## Requirements
- R1: Every burst has a `burstcount` between 1 and `MAX_BURST`. With `ALIGN_EN`=0, every burst except the last of a command has exactly `MAX_BURST` words.
- R2: With `ALIGN_EN`=1, no burst crosses an address that is a multiple of `DATA_W/8*MAX_BURST` bytes. The first burst of an unaligned start ends exactly at the next such edge. Later bursts are `MAX_BURST` long while enough words remain.
- R3: The first burst of a command uses the command address. Each later burst address equals the previous burst address plus the previous `burstcount` times `DATA_W/8`.
- R4: The last burst of a command carries only the words still left. The sum of all burst counts equals the command word count.
- R5: While `mm_read` is high and `mm_waitrequest` is high, `mm_read`, `mm_addr` and `mm_burstcount` stay unchanged on the next cycle. A burst is taken on a cycle where `mm_read` is high and `mm_waitrequest` is low.
- R6: FIFO occupancy plus the number of words requested but not yet returned never exceeds `FIFO_DEPTH`. While the stream is stalled, issue stops at that limit, and no returned word is lost.
- R7: The stream delivers exactly the command's word count, in ascending address order.
- R8: `done` is high for exactly one cycle, in the cycle after the last word's stream handshake. `cmd_ready` is high only when no command is active.
- R9: A command is illegal when its address is not a multiple of `DATA_W/8` or `cmd_len/(DATA_W/8)` is zero (the low length bits are ignored). An illegal command raises `cmd_err` for one cycle and issues no read and no `done`.
- R10: After reset, `mm_read`, `st_valid`, `done` and `cmd_err` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Length in bytes |
| cmd_err | output | 1 | Illegal command pulse |
| mm_read | output | 1 | Burst read request |
| mm_addr | output | ADDR_W | Burst byte address |
| mm_burstcount | output | BC_W | Words in burst |
| mm_waitrequest | input | 1 | Slave stall |
| mm_readdata | input | DATA_W | Returned word |
| mm_readdatavalid | input | 1 | Returned word valid |
| st_data | output | DATA_W | Stream word |
| st_valid | output | 1 | Stream word valid |
| st_ready | input | 1 | Stream sink ready |
| done | output | 1 | Command complete pulse |

## Verification
Burst acceptance and word return can fall in the same cycle. In that cycle the outstanding-word count rises by the burst length and falls by one, while the FIFO also fills or drains. Random `waitrequest` and random sink readiness push these events together, and a long sink stall pushes the credit to its exact limit. The bench judges the result through the burst log, which must hold exactly the full FIFO depth during the stall, and through the delivered word sequence, which must lose nothing.

// File: rtl/brm_pkg.sv
`timescale 1ns/1ps
package brm_pkg;

  // Words in the next burst: limited by what is left and by the burst cap,
  // and (aligned variant) by the distance to the next window edge.
  function automatic int unsigned burst_words(input int unsigned word_ofs,
                                              input int unsigned left,
                                              input int unsigned max_b,
                                              input bit          align);
    int unsigned room;
    room = align ? (max_b - word_ofs) : max_b;
    return (left < room) ? left : room;
  endfunction

endpackage

// File: rtl/brm_burst_calc.sv
`timescale 1ns/1ps
module brm_burst_calc #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int OFS_W     = 2,
  parameter int MAX_BURST = 16,
  parameter bit ALIGN_EN  = 1'b1,
  parameter int BC_W      = $clog2(MAX_BURST) + 1
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  words_left,
  output logic [BC_W-1:0]   burst_len
);
  import brm_pkg::*;
  localparam int MB_W = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;

  logic [MB_W-1:0] win_ofs;
  logic [31:0]     pick;

  generate
    if (ALIGN_EN) begin : g_aligned
      assign win_ofs = cur_addr[OFS_W +: MB_W];
      assign pick = burst_words(32'(win_ofs), 32'(words_left), MAX_BURST, 1'b1);
    end else begin : g_free
      assign win_ofs = '0;
      assign pick = burst_words(32'd0, 32'(words_left), MAX_BURST, 1'b0);
    end
  endgenerate

  assign burst_len = BC_W'(pick);
endmodule

// File: rtl/brm_fifo.sv
`timescale 1ns/1ps
module brm_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic              not_empty,
  output logic [CNT_W-1:0]  count
);
  localparam int PW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic              do_rd;

  assign not_empty = (count != '0);
  assign do_rd     = rd && not_empty;
  assign rdata     = mem[rp];

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr)    wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      count <= count + CNT_W'(wr) - CNT_W'(do_rd);
    end
  end
endmodule

// File: rtl/brm_issue.sv
`timescale 1ns/1ps
module brm_issue #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int OFS_W      = 2,
  parameter int BPW        = 4,
  parameter int BC_W       = 5,
  parameter int FIFO_DEPTH = 32,
  parameter int CNT_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_ready,
  output logic              cmd_err,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  issue_left,
  input  logic [BC_W-1:0]   burst_len,
  output logic              mm_read,
  input  logic              mm_waitrequest,
  input  logic              rd_beat,
  input  logic [CNT_W-1:0]  fifo_cnt,
  input  logic              pop,
  output logic              accept,
  output logic [CNT_W-1:0]  outst,
  output logic              done
);
  logic             busy;
  logic [LEN_W-1:0] deliver_left;
  logic [LEN_W-1:0] cmd_words;
  logic             cmd_ok;
  logic [CNT_W:0]   room;

  assign cmd_words = cmd_len >> OFS_W;
  assign cmd_ok    = (cmd_addr[OFS_W-1:0] == '0) && (cmd_words != '0);
  assign cmd_ready = !busy;

  assign room    = (CNT_W+1)'(FIFO_DEPTH) - {1'b0, fifo_cnt} - {1'b0, outst};
  assign mm_read = busy && (issue_left != '0) && (room >= (CNT_W+1)'(burst_len));
  assign accept  = mm_read && !mm_waitrequest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      cur_addr     <= '0;
      issue_left   <= '0;
      deliver_left <= '0;
      outst        <= '0;
      done         <= 1'b0;
      cmd_err      <= 1'b0;
    end else begin
      done    <= 1'b0;
      cmd_err <= 1'b0;
      outst   <= outst + (accept ? CNT_W'(burst_len) : '0) - CNT_W'(rd_beat);
      if (!busy) begin
        if (cmd_valid) begin
          if (cmd_ok) begin
            busy         <= 1'b1;
            cur_addr     <= cmd_addr;
            issue_left   <= cmd_words;
            deliver_left <= cmd_words;
          end else begin
            cmd_err <= 1'b1;
          end
        end
      end else begin
        if (accept) begin
          cur_addr   <= cur_addr + ADDR_W'(burst_len) * ADDR_W'(BPW);
          issue_left <= issue_left - LEN_W'(burst_len);
        end
        if (pop) begin
          deliver_left <= deliver_left - 1'b1;
          if (deliver_left == LEN_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/burst_rd_master.sv
`timescale 1ns/1ps
module burst_rd_master #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int MAX_BURST  = 16,
  parameter bit ALIGN_EN   = 1'b1,
  parameter int FIFO_DEPTH = 2 * MAX_BURST,
  parameter int BC_W       = $clog2(MAX_BURST) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_err,
  output logic              mm_read,
  output logic [ADDR_W-1:0] mm_addr,
  output logic [BC_W-1:0]   mm_burstcount,
  input  logic              mm_waitrequest,
  input  logic [DATA_W-1:0] mm_readdata,
  input  logic              mm_readdatavalid,
  output logic [DATA_W-1:0] st_data,
  output logic              st_valid,
  input  logic              st_ready,
  output logic              done
);
  localparam int BPW   = DATA_W / 8;
  localparam int OFS_W = $clog2(BPW);
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  issue_left;
  logic [BC_W-1:0]   burst_len;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [CNT_W-1:0]  outst;
  logic              accept;
  logic              pop;

  assign pop           = st_valid && st_ready;
  assign mm_addr       = cur_addr;
  assign mm_burstcount = burst_len;

  brm_burst_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFS_W(OFS_W),
    .MAX_BURST(MAX_BURST), .ALIGN_EN(ALIGN_EN), .BC_W(BC_W)
  ) u_calc (
    .cur_addr(cur_addr), .words_left(issue_left), .burst_len(burst_len)
  );

  brm_issue #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFS_W(OFS_W), .BPW(BPW),
    .BC_W(BC_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
  ) u_issue (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_ready(cmd_ready), .cmd_err(cmd_err),
    .cur_addr(cur_addr), .issue_left(issue_left), .burst_len(burst_len),
    .mm_read(mm_read), .mm_waitrequest(mm_waitrequest),
    .rd_beat(mm_readdatavalid), .fifo_cnt(fifo_cnt), .pop(pop),
    .accept(accept), .outst(outst), .done(done)
  );

  brm_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr(mm_readdatavalid), .wdata(mm_readdata),
    .rd(st_ready), .rdata(st_data), .not_empty(st_valid), .count(fifo_cnt)
  );
endmodule

// File: rtl/brm_checker.sv
`timescale 1ns/1ps
module brm_checker #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int MAX_BURST  = 16,
  parameter bit ALIGN_EN   = 1'b1,
  parameter int FIFO_DEPTH = 32,
  parameter int BC_W       = 5,
  parameter int CNT_W      = 6,
  parameter int OFS_W      = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mm_read,
  input logic              mm_waitrequest,
  input logic [ADDR_W-1:0] mm_addr,
  input logic [BC_W-1:0]   mm_burstcount,
  input logic [LEN_W-1:0]  issue_left,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic [CNT_W-1:0]  outst,
  input logic              done,
  input logic              cmd_err
);
  localparam int MB_W = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;

  a_r1_burst_range: assert property (@(posedge clk) disable iff (!rst_n)
    mm_read |-> (mm_burstcount != '0) && (mm_burstcount <= BC_W'(MAX_BURST)));

  a_r2_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (ALIGN_EN && mm_read) |->
      (32'(mm_addr[OFS_W +: MB_W]) + 32'(mm_burstcount) <= 32'(MAX_BURST)));

  a_r4_within_left: assert property (@(posedge clk) disable iff (!rst_n)
    mm_read |-> (LEN_W'(mm_burstcount) <= issue_left));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_read && mm_waitrequest) |=>
      (mm_read && $stable(mm_addr) && $stable(mm_burstcount)));

  a_r6_credit: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fifo_cnt) + 32'(outst)) <= 32'(FIFO_DEPTH));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (!mm_read && !done));
endmodule

bind burst_rd_master brm_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .ALIGN_EN(ALIGN_EN),
  .FIFO_DEPTH(FIFO_DEPTH), .BC_W(BC_W), .CNT_W(CNT_W), .OFS_W(OFS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mm_read(mm_read), .mm_waitrequest(mm_waitrequest),
  .mm_addr(mm_addr), .mm_burstcount(mm_burstcount), .issue_left(issue_left),
  .fifo_cnt(fifo_cnt), .outst(outst), .done(done), .cmd_err(cmd_err)
);

// File: tb/burst_rd_master_bench.sv
`timescale 1ns/1ps
module brm_tb_mem #(parameter int BC_W = 4) (
  input  logic            clk,
  input  logic            mm_read,
  input  logic [31:0]     mm_addr,
  input  logic [BC_W-1:0] mm_burstcount,
  output logic            mm_waitrequest,
  output logic [31:0]     rdata,
  output logic            rvalid,
  input  logic            st_valid,
  input  logic [31:0]     st_data,
  output logic            st_ready,
  input  logic            done,
  input  logic            cmd_err,
  input  int              wait_mode,
  input  int              rdy_mode
);
  logic [31:0] b_addr [256];
  int          b_len  [256];
  int          nb = 0;
  logic [31:0] beats  [1024];
  int          nbt = 0;
  int          ndone = 0, nerr = 0, beats_at_done = 0;
  logic [31:0] pa [256];
  int          pl [256];
  int          head = 0, tail = 0;
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    mm_waitrequest = 1'b0;
    rvalid = 1'b0;
    rdata = '0;
    st_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (done === 1'b1) begin ndone++; beats_at_done = nbt; end
      if (cmd_err === 1'b1) nerr++;
      rvalid = 1'b0;
      if (head != tail) begin
        rvalid = 1'b1;
        rdata = pa[head] * 3 + 1;
        pa[head] = pa[head] + 4;
        pl[head] = pl[head] - 1;
        if (pl[head] == 0) head = (head + 1) % 256;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mm_waitrequest = (wait_mode != 0) && lfsr[0] && lfsr[3];
      st_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (lfsr[5] | lfsr[7]) : 1'b0;
      #1;
      if (mm_read === 1'b1 && !mm_waitrequest) begin
        b_addr[nb % 256] = mm_addr;
        b_len[nb % 256] = int'(mm_burstcount);
        nb++;
        pa[tail] = mm_addr;
        pl[tail] = int'(mm_burstcount);
        tail = (tail + 1) % 256;
      end
      if (st_valid === 1'b1 && st_ready) begin
        beats[nbt % 1024] = st_data;
        nbt++;
      end
    end
  end
endmodule

module burst_rd_master_bench;
  localparam int MAXB = 8;
  localparam int BCW  = 4;
  localparam int DEP  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  int wait_mode = 0, rdy_mode = 0;

  // instance with alignment (a) and without (f)
  logic c_valid [2];
  logic [31:0] c_addr [2];
  logic [15:0] c_len [2];
  logic cmd_ready_a, cmd_err_a, mm_read_a, mm_wait_a, rvalid_a, st_valid_a, st_ready_a, done_a;
  logic cmd_ready_f, cmd_err_f, mm_read_f, mm_wait_f, rvalid_f, st_valid_f, st_ready_f, done_f;
  logic [31:0] mm_addr_a, rdata_a, st_data_a, mm_addr_f, rdata_f, st_data_f;
  logic [BCW-1:0] bc_a, bc_f;

  burst_rd_master #(.MAX_BURST(MAXB), .ALIGN_EN(1'b1), .FIFO_DEPTH(DEP)) u_burst_rd_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(c_valid[0]), .cmd_ready(cmd_ready_a),
    .cmd_addr(c_addr[0]), .cmd_len(c_len[0]), .cmd_err(cmd_err_a),
    .mm_read(mm_read_a), .mm_addr(mm_addr_a), .mm_burstcount(bc_a),
    .mm_waitrequest(mm_wait_a), .mm_readdata(rdata_a), .mm_readdatavalid(rvalid_a),
    .st_data(st_data_a), .st_valid(st_valid_a), .st_ready(st_ready_a), .done(done_a));

  brm_tb_mem #(.BC_W(BCW)) u_mem_a (
    .clk(clk), .mm_read(mm_read_a), .mm_addr(mm_addr_a), .mm_burstcount(bc_a),
    .mm_waitrequest(mm_wait_a), .rdata(rdata_a), .rvalid(rvalid_a),
    .st_valid(st_valid_a), .st_data(st_data_a), .st_ready(st_ready_a),
    .done(done_a), .cmd_err(cmd_err_a), .wait_mode(wait_mode), .rdy_mode(rdy_mode));

  burst_rd_master #(.MAX_BURST(MAXB), .ALIGN_EN(1'b0), .FIFO_DEPTH(DEP)) u_free (
    .clk(clk), .rst_n(rst_n), .cmd_valid(c_valid[1]), .cmd_ready(cmd_ready_f),
    .cmd_addr(c_addr[1]), .cmd_len(c_len[1]), .cmd_err(cmd_err_f),
    .mm_read(mm_read_f), .mm_addr(mm_addr_f), .mm_burstcount(bc_f),
    .mm_waitrequest(mm_wait_f), .mm_readdata(rdata_f), .mm_readdatavalid(rvalid_f),
    .st_data(st_data_f), .st_valid(st_valid_f), .st_ready(st_ready_f), .done(done_f));

  brm_tb_mem #(.BC_W(BCW)) u_mem_f (
    .clk(clk), .mm_read(mm_read_f), .mm_addr(mm_addr_f), .mm_burstcount(bc_f),
    .mm_waitrequest(mm_wait_f), .rdata(rdata_f), .rvalid(rvalid_f),
    .st_valid(st_valid_f), .st_data(st_data_f), .st_ready(st_ready_f),
    .done(done_f), .cmd_err(cmd_err_f), .wait_mode(wait_mode), .rdy_mode(rdy_mode));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // snapshot of one instance's logs
  int s_nb, s_nbt, s_ndone, s_nerr;
  task automatic snap(input int inst);
    if (inst == 0) begin s_nb = u_mem_a.nb; s_nbt = u_mem_a.nbt; s_ndone = u_mem_a.ndone; s_nerr = u_mem_a.nerr; end
    else begin s_nb = u_mem_f.nb; s_nbt = u_mem_f.nbt; s_ndone = u_mem_f.ndone; s_nerr = u_mem_f.nerr; end
  endtask

  task automatic send(input int inst, input logic [31:0] a, input logic [15:0] l);
    @(negedge clk);
    c_addr[inst] = a; c_len[inst] = l; c_valid[inst] = 1'b1;
    @(negedge clk);
    c_valid[inst] = 1'b0;
  endtask

  // Expected burst list, derived from R1, R2 and R4.
  int exp_l [64];
  int nexp;
  task automatic plan(input logic [31:0] a, input int n, input bit al);
    int left = n;
    int word = int'(a >> 2);
    nexp = 0;
    while (left > 0) begin
      int lim = al ? (MAXB - (word % MAXB)) : MAXB;
      int b = (left < lim) ? left : lim;
      exp_l[nexp] = b;
      nexp++;
      word += b;
      left -= b;
    end
  endtask

  task automatic run_and_check(input int inst, input logic [31:0] a, input int n,
                               input bit al, input string tag);
    int nb, nbt, nd, bad_len, bad_addr, bad_data, bad_cross, at_done, sum;
    logic [31:0] ea;
    plan(a, n, al);
    snap(inst);
    send(inst, a, 16'(n * 4));
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (((inst == 0) ? u_mem_a.ndone : u_mem_f.ndone) > s_ndone) break;
    end
    repeat (3) @(negedge clk);
    nb  = ((inst == 0) ? u_mem_a.nb  : u_mem_f.nb)  - s_nb;
    nbt = ((inst == 0) ? u_mem_a.nbt : u_mem_f.nbt) - s_nbt;
    nd  = ((inst == 0) ? u_mem_a.ndone : u_mem_f.ndone) - s_ndone;
    at_done = ((inst == 0) ? u_mem_a.beats_at_done : u_mem_f.beats_at_done) - s_nbt;
    bad_len = 0; bad_addr = 0; bad_data = 0; bad_cross = 0; sum = 0;
    ea = a;
    for (int i = 0; i < nb && i < 64; i++) begin
      int bl = (inst == 0) ? u_mem_a.b_len[(s_nb + i) % 256] : u_mem_f.b_len[(s_nb + i) % 256];
      logic [31:0] ba = (inst == 0) ? u_mem_a.b_addr[(s_nb + i) % 256] : u_mem_f.b_addr[(s_nb + i) % 256];
      if (i >= nexp || bl != exp_l[i]) bad_len++;
      if (ba != ea) bad_addr++;
      if (al && ((ba / (4 * MAXB)) != ((ba + 32'(bl * 4) - 1) / (4 * MAXB)))) bad_cross++;
      sum += bl;
      ea = ba + 32'(bl * 4);
    end
    for (int i = 0; i < nbt; i++) begin
      logic [31:0] d = (inst == 0) ? u_mem_a.beats[(s_nbt + i) % 1024] : u_mem_f.beats[(s_nbt + i) % 1024];
      if (d != (a + 32'(i * 4)) * 3 + 1) bad_data++;
    end
    check(nb == nexp, {tag, " R1 burst count"}, nb, nexp);
    check(bad_len == 0, {tag, " R2/R4 burst lengths"}, bad_len, 0);
    check(bad_cross == 0, {tag, " R2 boundary crossings"}, bad_cross, 0);
    check(bad_addr == 0, {tag, " R3 address advance"}, bad_addr, 0);
    check(sum == n, {tag, " R4 total words requested"}, sum, n);
    check(nbt == n, {tag, " R7 words delivered"}, nbt, n);
    check(bad_data == 0, {tag, " R7 word order"}, bad_data, 0);
    check(nd == 1, {tag, " R8 one done"}, nd, 1);
    check(at_done == n, {tag, " R8 done after last word"}, at_done, n);
  endtask

  task automatic t_reset;
    check(mm_read_a == 1'b0 && st_valid_a == 1'b0, "R10 read/stream idle", {mm_read_a, st_valid_a}, 0);
    check(done_a == 1'b0 && cmd_err_a == 1'b0, "R10 pulses low", {done_a, cmd_err_a}, 0);
    check(cmd_ready_a == 1'b1 && cmd_ready_f == 1'b1, "R10 R8 ready when idle", cmd_ready_a, 1);
  endtask

  task automatic t_aligned_start;
    wait_mode = 0; rdy_mode = 0;
    run_and_check(0, 32'h100, 20, 1'b1, "aligned start");
  endtask

  task automatic t_unaligned_start;
    wait_mode = 1; rdy_mode = 1;
    run_and_check(0, 32'h10C, 30, 1'b1, "unaligned start");
    check(nexp == 5 && exp_l[0] == 5, "R2 first burst shortened to edge", exp_l[0], 5);
  endtask

  task automatic t_no_align;
    wait_mode = 1; rdy_mode = 1;
    run_and_check(1, 32'h10C, 30, 1'b0, "alignment off");
    check(u_mem_f.b_len[s_nb % 256] == MAXB, "R1 full first burst without alignment",
          u_mem_f.b_len[s_nb % 256], MAXB);
  endtask

  task automatic t_short_tail;
    wait_mode = 1; rdy_mode = 0;
    run_and_check(0, 32'h18, 3, 1'b1, "short tail");
  endtask

  task automatic t_busy_ready;
    // R8: cmd_ready low while a command runs
    wait_mode = 0; rdy_mode = 2;
    snap(0);
    send(0, 32'h400, 16'd16);
    repeat (4) @(negedge clk);
    check(cmd_ready_a == 1'b0, "R8 cmd_ready low while active", cmd_ready_a, 0);
    rdy_mode = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (u_mem_a.ndone > s_ndone) break;
    end
    @(negedge clk);
    check(cmd_ready_a == 1'b1, "R8 cmd_ready back after done", cmd_ready_a, 1);
  endtask

  task automatic t_backpressure;
    int issued;
    wait_mode = 1; rdy_mode = 2;
    snap(0);
    send(0, 32'h200, 16'd160);
    repeat (300) @(negedge clk);
    issued = 0;
    for (int i = s_nb; i < u_mem_a.nb; i++) issued += u_mem_a.b_len[i % 256];
    check(issued == DEP, "R6 issue stops at FIFO depth", issued, DEP);
    check(u_mem_a.nbt == s_nbt, "R6 nothing delivered while stalled", u_mem_a.nbt - s_nbt, 0);
    rdy_mode = 1;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (u_mem_a.ndone > s_ndone) break;
    end
    repeat (2) @(negedge clk);
    check(u_mem_a.nbt - s_nbt == 40, "R6 R7 no word lost", u_mem_a.nbt - s_nbt, 40);
    begin
      int bad = 0;
      for (int i = 0; i < 40; i++)
        if (u_mem_a.beats[(s_nbt + i) % 1024] != (32'h200 + 32'(i * 4)) * 3 + 1) bad++;
      check(bad == 0, "R6 R7 data after stall", bad, 0);
    end
  endtask

  task automatic t_illegal;
    wait_mode = 0; rdy_mode = 0;
    snap(0);
    send(0, 32'h102, 16'd32);
    repeat (10) @(negedge clk);
    check(u_mem_a.nerr - s_nerr == 1, "R9 error on byte-offset address", u_mem_a.nerr - s_nerr, 1);
    check(u_mem_a.nb == s_nb, "R9 no read on byte-offset address", u_mem_a.nb - s_nb, 0);
    check(u_mem_a.ndone == s_ndone, "R9 no done on error", u_mem_a.ndone - s_ndone, 0);
    snap(0);
    send(0, 32'h100, 16'd3);
    repeat (10) @(negedge clk);
    check(u_mem_a.nerr - s_nerr == 1, "R9 error on zero word length", u_mem_a.nerr - s_nerr, 1);
    check(u_mem_a.nb == s_nb, "R9 no read on zero word length", u_mem_a.nb - s_nb, 0);
    check(cmd_ready_a == 1'b1, "R9 still idle after error", cmd_ready_a, 1);
  endtask

  initial begin
    c_valid[0] = 1'b0; c_valid[1] = 1'b0;
    c_addr[0] = '0; c_addr[1] = '0; c_len[0] = '0; c_len[1] = '0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_aligned_start();
    t_unaligned_start();
    t_no_align();
    t_short_tail();
    t_busy_ready();
    t_backpressure();
    t_illegal();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule